// File: doc/BRIEF.md
# Pipelined Cartesian-to-Polar Converter

This block takes one signed Cartesian sample pair (X, Y) on every clock and returns its length and its angle. The magnitude comes out as a 16-bit unsigned value and the angle as a 12-bit unsigned code that spans the whole circle. The pipeline has a fixed depth, so a stream of samples comes out as a stream of results, one per clock, with no gaps and no handshake.

Each sample carries its own number-format bit, so two's complement and sign-magnitude words can be mixed freely. The X and Y input registers each have an active-low load enable. A registered 2-bit scale control shifts the magnitude left by up to three places, and a flag marks any output whose shifted value no longer fits. Each output port has an active-low enable. When it is off, the port reads zero and its valid line is low.

Internally, a vectoring CORDIC runs on the sample after it has been folded into the right half-plane. A constant multiply then removes the CORDIC gain. Samples that lie on an axis, and the origin, are detected on entry and given exact angle codes.

Top module: `cart2polar`

## Requirements
- R1: A sample captured on clock edge k produces its magnitude and phase on the outputs right after edge k+24. A new sample is accepted on every edge.
- R2: The format bit is captured on the same edge as the data it describes. With 0, X and Y are two's complement. With 1, they are sign-magnitude: bit 15 is the sign and bits 14:0 are the magnitude, so 0x8000 means zero. The format may differ from one sample to the next.
- R3: At scale code 0, the magnitude output equals sqrt(X²+Y²), counted in input LSBs, within ±2 LSB. It is unsigned with 16 bits, so its MSB weighs 1 when the input MSB (below the sign) weighs 0.5.
- R4: The phase output equals atan2(Y,X), mapped into [0, 2π) and counted in units of 2π/4096, within ±1 LSB modulo 4096. This accuracy holds for vectors of length at least 1024 LSB.
- R5: Points on an axis give exact phase codes: Y=0 and X>0 gives 0x000, X=0 and Y>0 gives 0x400, Y=0 and X<0 gives 0x800, and X=0 and Y<0 gives 0xC00.
- R6: X=0 and Y=0 give magnitude 0 and phase 0x000.
- R7: Scale codes 0, 1, 2 and 3 shift the magnitude left by 0, 1, 2 and 3 places. A code captured on edge k governs the magnitude presented right after edge k+1.
- R8: The overflow output is high exactly in the cycles whose magnitude output lost a nonzero bit to the shift.
- R9: The X register loads only on edges where ceXn is 0, and the Y register loads only on edges where ceYn is 0. Otherwise each holds its previous sample, and that sample keeps flowing into the pipeline.
- R10: While oeMagN (or oePhsN) is 1, the matching data output reads 0 and its valid output is 0. A valid output is 1 only if its enable is 0 and at least 25 edges have passed since reset was released.
- R11: During reset, all data outputs, the overflow flag and both valid outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| xIn | input | 16 | X sample word |
| yIn | input | 16 | Y sample word |
| ceXn | input | 1 | Active-low load enable of the X register |
| ceYn | input | 1 | Active-low load enable of the Y register |
| fmtSm | input | 1 | Format of this sample: 0 two's complement, 1 sign-magnitude |
| scaleSel | input | 2 | Magnitude left-shift amount, 0 to 3 |
| oeMagN | input | 1 | Active-low enable of the magnitude port |
| oePhsN | input | 1 | Active-low enable of the phase port |
| magOut | output | 16 | Scaled magnitude |
| phsOut | output | 12 | Full-circle phase code |
| ovrFlag | output | 1 | High while the magnitude output lost bits to scaling |
| magValid | output | 1 | Magnitude port enabled and pipeline primed |
| phsValid | output | 1 | Phase port enabled and pipeline primed |

## Verification
The axis points (short and full-scale), the origin and sign-magnitude negative zero show whether the entry classifier forces the exact codes and bypasses the CORDIC. Uniform random two's-complement pairs exercise the fold and the iterations in all four quadrants, while random pairs with a format bit that flips per sample show whether the format is tied to its own sample. A scale code that cycles every clock, applied to vectors of several lengths, separates a scaler that is one cycle early or late from a correct one and places samples on both sides of the overflow edge. Random toggling of the load enables and output enables shows held samples still flowing through, and ports gating at once.

// File: rtl/cart2polar_pkg.sv
package cart2polar_pkg;

  // Internal angle accumulator: full circle maps to 2**ANG_W
  localparam int ANG_W      = 16;
  // CORDIC gain compensation 1/1.64676 in unsigned Q0.KGAIN_FRAC
  localparam int KGAIN_FRAC = 17;
  localparam int KGAIN_W    = 17;
  localparam logic [KGAIN_W-1:0] KGAIN = 17'd79595;

  typedef struct packed {
    logic       loadX;
    logic       loadY;
    logic [1:0] scale;
    logic       magDrive;
    logic       phsDrive;
  } cpStrobe_t;

  // atan(2**-idx) scaled to a 2**ANG_W full circle
  function automatic logic [ANG_W-1:0] atanStep(input int idx);
    case (idx)
      0:  return 16'd8192;
      1:  return 16'd4836;
      2:  return 16'd2555;
      3:  return 16'd1297;
      4:  return 16'd651;
      5:  return 16'd326;
      6:  return 16'd163;
      7:  return 16'd81;
      8:  return 16'd41;
      9:  return 16'd20;
      10: return 16'd10;
      11: return 16'd5;
      12: return 16'd3;
      13: return 16'd1;
      14: return 16'd1;
      default: return 16'd0;
    endcase
  endfunction

endpackage

// File: rtl/cart2polar_ctrl.sv
module cart2polar_ctrl
  import cart2polar_pkg::*;
#(
  parameter int LATENCY = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceXn,
  input  logic       ceYn,
  input  logic [1:0] scaleIn,
  input  logic       oeMagN,
  input  logic       oePhsN,
  output cpStrobe_t  st,
  output logic       magValid,
  output logic       phsValid
);

  localparam int CNT_W = $clog2(LATENCY + 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(LATENCY + 1);

  logic [1:0]       scaleQ;
  logic [CNT_W-1:0] fillCnt;
  logic             primed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scaleQ  <= '0;
      fillCnt <= '0;
    end else begin
      scaleQ <= scaleIn;
      if (fillCnt != FULL) fillCnt <= fillCnt + 1'b1;
    end
  end

  assign primed      = (fillCnt == FULL);
  assign st.loadX    = ~ceXn;
  assign st.loadY    = ~ceYn;
  assign st.scale    = scaleQ;
  assign st.magDrive = ~oeMagN;
  assign st.phsDrive = ~oePhsN;
  assign magValid    = primed & ~oeMagN;
  assign phsValid    = primed & ~oePhsN;

  // R10: once primed, valid only drops because the port enable is released
  a_r10_valid_holds: assert property (@(posedge clk) disable iff (!rstN)
    magValid |=> (magValid || oeMagN));
  a_r10_phs_valid_holds: assert property (@(posedge clk) disable iff (!rstN)
    phsValid |=> (phsValid || oePhsN));

endmodule

// File: rtl/cart2polar_dp.sv
module cart2polar_dp
  import cart2polar_pkg::*;
#(
  parameter int IN_W    = 16,
  parameter int MAG_W   = 16,
  parameter int PH_W    = 12,
  parameter int ITERS   = 14,
  parameter int GUARD   = 6,
  parameter int LATENCY = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  cpStrobe_t         st,
  input  logic [IN_W-1:0]   xIn,
  input  logic [IN_W-1:0]   yIn,
  input  logic              fmtSm,
  output logic [MAG_W-1:0]  magOut,
  output logic [PH_W-1:0]   phsOut,
  output logic              ovrFlag
);

  localparam int W    = IN_W + 2 + GUARD;
  localparam int PAD  = LATENCY - ITERS - 3;
  localparam int PW   = W + KGAIN_W;
  localparam int SH   = KGAIN_FRAC + GUARD;
  localparam logic [PW-1:0]    RND  = PW'(1) << (SH - 1);
  localparam logic [ANG_W-1:0] PRND = ANG_W'(1) << (ANG_W - PH_W - 1);
  localparam logic [PH_W-1:0]  Q1   = PH_W'(1) << (PH_W - 2);
  localparam logic [PH_W-1:0]  Q2   = PH_W'(2) << (PH_W - 2);
  localparam logic [PH_W-1:0]  Q3   = PH_W'(3) << (PH_W - 2);

  typedef struct packed {
    logic signed [W-1:0] x;
    logic signed [W-1:0] y;
    logic [ANG_W-1:0]    z;
    logic                fixOn;
    logic [PH_W-1:0]     fixPh;
  } stage_t;

  function automatic logic signed [IN_W-1:0] decodeIn(input logic [IN_W-1:0] code,
                                                      input logic sm);
    logic signed [IN_W-1:0] mag;
    mag = $signed({1'b0, code[IN_W-2:0]});
    if (!sm) return $signed(code);
    else if (code[IN_W-1]) return -mag;
    else return mag;
  endfunction

  function automatic stage_t cordicStep(input stage_t s, input int idx);
    stage_t r;
    logic signed [W-1:0] dx, dy;
    dx = $signed(s.y) >>> idx;
    dy = $signed(s.x) >>> idx;
    r  = s;
    if (!s.y[W-1]) begin
      r.x = s.x + dx;
      r.y = s.y - dy;
      r.z = s.z + atanStep(idx);
    end else begin
      r.x = s.x - dx;
      r.y = s.y + dy;
      r.z = s.z - atanStep(idx);
    end
    return r;
  endfunction

  // Input capture, format applied on the loading edge
  logic signed [IN_W-1:0] xQ, yQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xQ <= '0;
      yQ <= '0;
    end else begin
      if (st.loadX) xQ <= decodeIn(xIn, fmtSm);
      if (st.loadY) yQ <= decodeIn(yIn, fmtSm);
    end
  end

  // R9: a disabled register keeps its sample
  a_r9_hold_x: assert property (@(posedge clk) disable iff (!rstN)
    !st.loadX |=> $stable(xQ));
  a_r9_hold_y: assert property (@(posedge clk) disable iff (!rstN)
    !st.loadY |=> $stable(yQ));

  // Fold into the right half-plane and classify axis points
  logic signed [W-1:0] xW, yW;
  stage_t foldD;
  assign xW = {{(W-IN_W-GUARD){xQ[IN_W-1]}}, xQ, {GUARD{1'b0}}};
  assign yW = {{(W-IN_W-GUARD){yQ[IN_W-1]}}, yQ, {GUARD{1'b0}}};

  always_comb begin
    foldD.fixOn = 1'b1;
    foldD.fixPh = '0;
    if (xQ[IN_W-1]) begin
      foldD.x = -xW;
      foldD.y = -yW;
      foldD.z = {1'b1, {(ANG_W-1){1'b0}}};
    end else begin
      foldD.x = xW;
      foldD.y = yW;
      foldD.z = '0;
    end
    if (yQ == '0 && !xQ[IN_W-1])      foldD.fixPh = '0;
    else if (xQ == '0 && !yQ[IN_W-1]) foldD.fixPh = Q1;
    else if (yQ == '0)                foldD.fixPh = Q2;
    else if (xQ == '0)                foldD.fixPh = Q3;
    else                              foldD.fixOn = 1'b0;
  end

  // Vectoring iterations
  stage_t pipe [0:ITERS];
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i <= ITERS; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= foldD;
      for (int i = 0; i < ITERS; i++) pipe[i+1] <= cordicStep(pipe[i], i);
    end
  end

  // Gain removal and phase rounding
  stage_t lastS;
  logic [PW-1:0]    prod;
  logic [ANG_W-1:0] zRnd;
  logic [MAG_W-1:0] magCalc, gainMag;
  logic [PH_W-1:0]  phCalc, gainPh;
  logic             unusedBits;

  assign lastS      = pipe[ITERS];
  assign unusedBits = ^{lastS.y, lastS.x[W-1]};

  always_comb begin
    prod    = PW'(lastS.x[W-2:0]) * PW'(KGAIN) + RND;
    magCalc = (|prod[PW-1:SH+MAG_W]) ? '1 : prod[SH +: MAG_W];
    zRnd    = lastS.z + PRND;
    phCalc  = lastS.fixOn ? lastS.fixPh : zRnd[ANG_W-1 -: PH_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gainMag <= '0;
      gainPh  <= '0;
    end else begin
      gainMag <= magCalc;
      gainPh  <= phCalc;
    end
  end

  // Delay padding to the fixed latency
  logic [MAG_W-1:0] magD;
  logic [PH_W-1:0]  phD;
  generate
    if (PAD > 0) begin : gPad
      logic [MAG_W-1:0] pm [0:PAD-1];
      logic [PH_W-1:0]  pp [0:PAD-1];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int k = 0; k < PAD; k++) begin
            pm[k] <= '0;
            pp[k] <= '0;
          end
        end else begin
          pm[0] <= gainMag;
          pp[0] <= gainPh;
          for (int k = 1; k < PAD; k++) begin
            pm[k] <= pm[k-1];
            pp[k] <= pp[k-1];
          end
        end
      end
      assign magD = pm[PAD-1];
      assign phD  = pp[PAD-1];
    end else begin : gNoPad
      assign magD = gainMag;
      assign phD  = gainPh;
    end
  endgenerate

  // Output stage: scaling and overflow
  logic [MAG_W-1:0] magQ;
  logic [PH_W-1:0]  phQ;
  logic             ovrQ, ovrCalc;

  always_comb begin
    case (st.scale)
      2'd0:    ovrCalc = 1'b0;
      2'd1:    ovrCalc = magD[MAG_W-1];
      2'd2:    ovrCalc = |magD[MAG_W-1 -: 2];
      default: ovrCalc = |magD[MAG_W-1 -: 3];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      magQ <= '0;
      phQ  <= '0;
      ovrQ <= 1'b0;
    end else begin
      magQ <= magD << st.scale;
      phQ  <= phD;
      ovrQ <= ovrCalc;
    end
  end

  // R8: unity scale can never overflow
  a_r8_unity_no_ovr: assert property (@(posedge clk) disable iff (!rstN)
    (st.scale == 2'd0) |=> !ovrQ);

  assign magOut  = st.magDrive ? magQ : '0;
  assign phsOut  = st.phsDrive ? phQ : '0;
  assign ovrFlag = ovrQ;

endmodule

// File: rtl/cart2polar.sv
module cart2polar
  import cart2polar_pkg::*;
#(
  parameter int IN_W    = 16,
  parameter int MAG_W   = 16,
  parameter int PH_W    = 12,
  parameter int ITERS   = 14,
  parameter int GUARD   = 6,
  parameter int LATENCY = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IN_W-1:0]  xIn,
  input  logic [IN_W-1:0]  yIn,
  input  logic             ceXn,
  input  logic             ceYn,
  input  logic             fmtSm,
  input  logic [1:0]       scaleSel,
  input  logic             oeMagN,
  input  logic             oePhsN,
  output logic [MAG_W-1:0] magOut,
  output logic [PH_W-1:0]  phsOut,
  output logic             ovrFlag,
  output logic             magValid,
  output logic             phsValid
);

  cpStrobe_t st;

  cart2polar_ctrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ceXn     (ceXn),
    .ceYn     (ceYn),
    .scaleIn  (scaleSel),
    .oeMagN   (oeMagN),
    .oePhsN   (oePhsN),
    .st       (st),
    .magValid (magValid),
    .phsValid (phsValid)
  );

  cart2polar_dp #(
    .IN_W(IN_W), .MAG_W(MAG_W), .PH_W(PH_W),
    .ITERS(ITERS), .GUARD(GUARD), .LATENCY(LATENCY)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .xIn     (xIn),
    .yIn     (yIn),
    .fmtSm   (fmtSm),
    .magOut  (magOut),
    .phsOut  (phsOut),
    .ovrFlag (ovrFlag)
  );

  // R10: a released port reads zero with valid low
  a_r10_mag_gate: assert property (@(posedge clk) disable iff (!rstN)
    oeMagN |-> (magOut == '0 && !magValid));
  a_r10_phs_gate: assert property (@(posedge clk) disable iff (!rstN)
    oePhsN |-> (phsOut == '0 && !phsValid));

endmodule

// File: tb/cart2polar_bench.sv
module cart2polar_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NMAX       = 2048;
  localparam int LAT        = 24;
  localparam real TWO_PI    = 6.283185307179586;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] xIn = '0, yIn = '0;
  logic        ceXn = 1'b0, ceYn = 1'b0, fmtSm = 1'b0;
  logic [1:0]  scaleSel = '0;
  logic        oeMagN = 1'b0, oePhsN = 1'b0;
  logic [15:0] magOut;
  logic [11:0] phsOut;
  logic        ovrFlag, magValid, phsValid;

  cart2polar u_cart2polar (
    .clk(clk), .rstN(rstN), .xIn(xIn), .yIn(yIn), .ceXn(ceXn), .ceYn(ceYn),
    .fmtSm(fmtSm), .scaleSel(scaleSel), .oeMagN(oeMagN), .oePhsN(oePhsN),
    .magOut(magOut), .phsOut(phsOut), .ovrFlag(ovrFlag),
    .magValid(magValid), .phsValid(phsValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int ecount = 0;
  always @(posedge clk) if (rstN) ecount <= ecount + 1;

  int    checks = 0, errors = 0;
  real   refMag [NMAX];
  real   refPh  [NMAX];
  int    refAxis[NMAX];
  string refTag [NMAX];
  int    scaleDrv[NMAX];
  int    xm = 0, ym = 0;

  task automatic chk(input bit ok, input string what, input real act, input real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0.2f expected=%0.2f", what, act, exp);
    end
  endtask

  function automatic int decodeIn(input logic [15:0] c, input bit sm);
    if (!sm) return int'($signed(c));
    return c[15] ? -int'(c[14:0]) : int'(c[14:0]);
  endfunction

  function automatic logic [15:0] enc(input int v, input bit sm);
    if (sm && v < 0) return {1'b1, 15'(-v)};
    return 16'(v);
  endfunction

  function automatic int rnd(input int lim);
    return int'($urandom_range(2 * lim)) - lim;
  endfunction

  task automatic record(input int idx, input string tag);
    real a;
    if (idx >= NMAX) return;
    refMag[idx] = $sqrt(real'(xm) * real'(xm) + real'(ym) * real'(ym));
    if (ym == 0 && xm >= 0)  refAxis[idx] = 0;
    else if (xm == 0 && ym > 0) refAxis[idx] = 1024;
    else if (ym == 0)        refAxis[idx] = 2048;
    else if (xm == 0)        refAxis[idx] = 3072;
    else                     refAxis[idx] = -1;
    a = $atan2(real'(ym), real'(xm));
    if (a < 0.0) a = a + TWO_PI;
    refPh[idx]  = a * 4096.0 / TWO_PI;
    refTag[idx] = tag;
  endtask

  task automatic checkOutputs(input int e);
    int  s;
    real scl, sc, tol, d;
    bit  amb, ovrExp;
    if (oeMagN) begin
      chk(magOut == 0, "R10 magnitude gated", real'(magOut), 0.0);
      chk(!magValid, "R10 magnitude valid gated", real'(magValid), 0.0);
    end else if (e < LAT + 1) begin
      chk(!magValid, "R10 magnitude valid before fill", real'(magValid), 0.0);
    end else begin
      chk(magValid, "R10 magnitude valid", real'(magValid), 1.0);
      s   = scaleDrv[e-1];
      scl = real'(1 << s);
      sc  = refMag[e] * scl;
      tol = 2.0 * scl + 0.5;
      amb = (sc > 65536.0 - 3.0 * scl) && (sc < 65536.0 + 3.0 * scl);
      ovrExp = (sc >= 65536.0);
      if (!amb) begin
        chk(ovrFlag == ovrExp, {refTag[e], " R8 overflow"}, real'(ovrFlag), real'(ovrExp));
        if (!ovrExp) begin
          d = real'(magOut) - sc;
          chk((d < 0.0 ? -d : d) <= tol, {refTag[e], " R3 magnitude"}, real'(magOut), sc);
        end
      end
    end
    if (oePhsN) begin
      chk(phsOut == 0, "R10 phase gated", real'(phsOut), 0.0);
      chk(!phsValid, "R10 phase valid gated", real'(phsValid), 0.0);
    end else if (e < LAT + 1) begin
      chk(!phsValid, "R10 phase valid before fill", real'(phsValid), 0.0);
    end else begin
      chk(phsValid, "R10 phase valid", real'(phsValid), 1.0);
      if (refAxis[e] >= 0) begin
        chk(int'(phsOut) == refAxis[e], (refMag[e] == 0.0) ? "R6 origin phase" : "R5 axis phase",
            real'(phsOut), real'(refAxis[e]));
      end else if (refMag[e] >= 1024.0) begin
        d = real'(phsOut) - refPh[e];
        if (d > 2048.0) d = d - 4096.0;
        if (d < -2048.0) d = d + 4096.0;
        chk((d < 0.0 ? -d : d) <= 1.5, {refTag[e], " R4 phase"}, real'(phsOut), refPh[e]);
      end
    end
  endtask

  task automatic step(input logic [15:0] cx, input logic [15:0] cy, input bit form,
                      input bit ceX, input bit ceY, input int scale,
                      input bit oeM, input bit oeP, input string tag);
    int e;
    @(negedge clk);
    e = ecount;
    checkOutputs(e);
    xIn = cx; yIn = cy; fmtSm = form;
    ceXn = ceX; ceYn = ceY; scaleSel = 2'(scale);
    if (!ceX) xm = decodeIn(cx, form);
    if (!ceY) ym = decodeIn(cy, form);
    record(e + LAT + 1, tag);
    if (e + 1 < NMAX) scaleDrv[e+1] = scale;
    oeMagN = oeM; oePhsN = oeP;
  endtask

  initial begin
    for (int i = 0; i < NMAX; i++) begin
      refMag[i] = 0.0; refPh[i] = 0.0; refAxis[i] = 0;
      refTag[i] = "R6"; scaleDrv[i] = 0;
    end
    // R11: reset state
    repeat (4) begin
      @(negedge clk);
      chk(magOut == 0 && phsOut == 0 && !ovrFlag && !magValid && !phsValid,
          "R11 reset outputs", real'(magOut) + real'(phsOut), 0.0);
    end
    rstN = 1'b1;

    // R5 / R6: axis points and origin, both formats
    step(enc(1000, 0),   enc(0, 0),      0, 0, 0, 0, 0, 0, "R5");
    step(enc(0, 0),      enc(1000, 0),   0, 0, 0, 0, 0, 0, "R5");
    step(enc(-1000, 0),  enc(0, 0),      0, 0, 0, 0, 0, 0, "R5");
    step(enc(0, 0),      enc(-1000, 0),  0, 0, 0, 0, 0, 0, "R5");
    step(enc(0, 0),      enc(0, 0),      0, 0, 0, 0, 0, 0, "R6");
    step(enc(32767, 0),  enc(0, 0),      0, 0, 0, 0, 0, 0, "R5");
    step(enc(0, 0),      enc(-32767, 0), 0, 0, 0, 0, 0, 0, "R5");
    step(16'h8000,       16'h8000,       1, 0, 0, 0, 0, 0, "R6");
    step(enc(-1000, 1),  16'h8000,       1, 0, 0, 0, 0, 0, "R5");
    step(enc(0, 1),      enc(-32767, 1), 1, 0, 0, 0, 0, 0, "R5");
    step(enc(3, 0),      enc(0, 0),      0, 0, 0, 0, 0, 0, "R5");

    // R1: random two's complement stream
    for (int i = 0; i < 200; i++)
      step(enc(rnd(32767), 0), enc(rnd(32767), 0), 0, 0, 0, 0, 0, 0, "R1");

    // R2: format flips per sample
    for (int i = 0; i < 200; i++) begin
      bit f;
      f = bit'($urandom_range(1));
      step(enc(rnd(32767), f), enc(rnd(32767), f), f, 0, 0, 0, 0, 0, "R2");
    end

    // R7 / R8: scale cycling each clock over several vector lengths
    for (int i = 0; i < 300; i++) begin
      int lim;
      lim = 32767 >> $urandom_range(3);
      step(enc(rnd(lim), 0), enc(rnd(lim), 0), 0, 0, 0, i % 4, 0, 0, "R7");
    end

    // R9: random load enables
    for (int i = 0; i < 200; i++)
      step(enc(rnd(32767), 0), enc(rnd(32767), 0), 0,
           bit'($urandom_range(1)), bit'($urandom_range(1)), 0, 0, 0, "R9");

    // R10: random output enables
    for (int i = 0; i < 100; i++)
      step(enc(rnd(32767), 0), enc(rnd(32767), 0), 0, 0, 0, int'($urandom_range(3)),
           bit'($urandom_range(1)), bit'($urandom_range(1)), "R10");

    // flush with origin samples
    for (int i = 0; i < 30; i++)
      step(enc(0, 0), enc(0, 0), 0, 0, 0, 0, 0, 0, "R6");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule